// File: doc/BRIEF.md
# Feedback Divider With Pulse Swallow

This block divides a stream of clock-enable ticks by a programmable modulus and then by a power-of-two post-scaler, producing a one-clock feedback pulse for a downstream phase detector. Two decoded sync outputs mark programmable windows inside each divider period. One-shot add and swallow commands shorten or lengthen a single divider period by one tick. This shifts the feedback phase by exactly one input cycle without changing the long-term ratio.

The block can also pass an external feedback signal straight through to the pulse output, with a programmable active edge. When software asks for internal feedback, the handover waits for the next active external edge. On that edge the internal counter restarts from zero, so the internal divider takes over phase-aligned to the external source.

Top module: `fbk_pulse_divider`

## Requirements
- R1: In internal mode the feedback pulse repeats every (modVal+1)*D ticks of `tickEn`, where D is the post-scale factor. A cycle without `tickEn` does not advance the divider. After reset the first pulse appears after (modVal+1)*D ticks.
- R2: `postCode` selects D: code 3 gives 1, code 2 gives 2, code 1 gives 4, code 0 gives 8.
- R3: A 0-to-1 change on `swallowCmd` makes the divider period that is running, or the next one if none is, one tick longer. A level held high afterwards has no further effect.
- R4: A 0-to-1 change on `addCmd` makes one divider period one tick shorter. A level held high afterwards has no further effect.
- R5: If an add and a swallow are both pending at a terminal count, that period keeps its normal length and both are cleared.
- R6: `syncLo` is high while bits [10:3] of the divider count equal `syncLoVal`, and `syncHi` is high while they equal `syncHiVal`. Count 0 is the state visible in the same cycle as the internal feedback pulse.
- R7: In external mode (`useInternal`=0) `fbkPulse` is high for one cycle, one clock after an active edge of `extFbk`. `extPol`=0 selects the rising edge and `extPol`=1 the falling edge. Internal terminal counts do not reach the output in this mode.
- R8: After `useInternal` rises, the switch to internal feedback happens only on an active `extFbk` edge. That edge still produces its pulse, and the counter restarts at 0 so the next pulse follows one full period later. Further external edges are then ignored. Clearing `useInternal` returns to external mode on the next clock.
- R9: `fbkPulse` is never high for two consecutive clocks while internal mode is steady and the modulus is at least 64.
- R10: Reset clears the counter, both pending commands and `fbkPulse`, and selects internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One input-cycle tick of the divided stream |
| modVal | input | 11 | Divide modulus minus one (legal 63..2047) |
| postCode | input | 2 | Post-scaler code (3:/1, 2:/2, 1:/4, 0:/8) |
| syncLoVal | input | 8 | Count state that drives `syncLo` |
| syncHiVal | input | 8 | Count state that drives `syncHi` |
| addCmd | input | 1 | Rising edge shortens one period by a tick |
| swallowCmd | input | 1 | Rising edge lengthens one period by a tick |
| useInternal | input | 1 | 1 requests internal feedback, 0 selects external |
| extPol | input | 1 | External active edge: 0 rising, 1 falling |
| extFbk | input | 1 | External feedback signal, synchronous to clk |
| fbkPulse | output | 1 | One-clock feedback pulse |
| syncLo | output | 1 | Decoded low sync state |
| syncHi | output | 1 | Decoded high sync state |

## Verification
An add and a swallow request can both be pending at the same terminal count. The bench provokes this by raising both commands on the same clock early in a period. It then judges the result by the gap between feedback pulses: that gap and the gap after it must both equal the plain modulus, with no lingering one-tick slip. The switchover edge is a second point where two functions meet, because the external pulse and the counter restart share one clock. The bench times the next internal pulse from that edge.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int PS_CODE_W = 2;
  localparam int PS_W = (1 << PS_CODE_W) - 1;

  typedef struct packed {
    logic restart;
    logic lengthen;
    logic shorten;
    logic selInt;
    logic extEdge;
  } fbdivCtl_t;
endpackage

// File: rtl/fbdiv_ctrl.sv
module fbdiv_ctrl
  import fbdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      addCmd,
  input  logic      swallowCmd,
  input  logic      useInternal,
  input  logic      extPol,
  input  logic      extFbk,
  input  logic      divTc,
  output fbdivCtl_t ctl
);
  logic addPrev, swPrev, extPrev;
  logic addPend, swPend, intSel;
  logic extEdge, addRise, swRise;

  // Edge history follows the inputs even during reset
  always_ff @(posedge clk) begin
    addPrev <= addCmd;
    swPrev  <= swallowCmd;
    extPrev <= extFbk;
  end

  assign extEdge = extPol ? (extPrev & ~extFbk) : (~extPrev & extFbk);
  assign addRise = addCmd & ~addPrev;
  assign swRise  = swallowCmd & ~swPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addPend <= 1'b0;
      swPend  <= 1'b0;
      intSel  <= 1'b1;
    end else begin
      addPend <= (addPend & ~divTc) | addRise;
      swPend  <= (swPend & ~divTc) | swRise;
      intSel  <= useInternal & (intSel | extEdge);
    end
  end

  always_comb begin
    ctl.restart  = ~intSel & useInternal & extEdge;
    ctl.lengthen = swPend & ~addPend;
    ctl.shorten  = addPend & ~swPend;
    ctl.selInt   = intSel;
    ctl.extEdge  = extEdge;
  end
endmodule

// File: rtl/fbdiv_dp.sv
module fbdiv_dp
  import fbdiv_pkg::*;
#(
  parameter int MOD_W  = 11,
  parameter int SYNC_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [MOD_W-1:0]     modVal,
  input  logic [PS_CODE_W-1:0] postCode,
  input  logic [SYNC_W-1:0]    syncLoVal,
  input  logic [SYNC_W-1:0]    syncHiVal,
  input  fbdivCtl_t            ctl,
  output logic                 divTc,
  output logic                 fbkPulse,
  output logic                 syncLo,
  output logic                 syncHi
);
  localparam int CNT_W = MOD_W + 1;

  logic [CNT_W-1:0]  cnt, endVal;
  logic [PS_W-1:0]   psCnt, psEnd;
  logic [PS_W:0]     psOne;
  logic              psLast, intFire;
  logic [SYNC_W-1:0] cntHigh;

  always_comb begin
    endVal = {1'b0, modVal} + CNT_W'(ctl.lengthen) - CNT_W'(ctl.shorten);
    psOne  = {{PS_W{1'b0}}, 1'b1} << (PS_W - int'(postCode));
    psEnd  = PS_W'(psOne - (PS_W + 1)'(1));
  end

  assign divTc   = tickEn & (cnt >= endVal);
  assign psLast  = (psCnt >= psEnd);
  assign intFire = divTc & psLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      psCnt    <= '0;
      fbkPulse <= 1'b0;
    end else begin
      if (ctl.restart) begin
        cnt   <= '0;
        psCnt <= '0;
      end else if (tickEn) begin
        cnt <= divTc ? '0 : cnt + CNT_W'(1);
        if (divTc) psCnt <= psLast ? '0 : psCnt + PS_W'(1);
      end
      fbkPulse <= ctl.selInt ? intFire : ctl.extEdge;
    end
  end

  assign cntHigh = cnt[MOD_W-1 -: SYNC_W];
  assign syncLo  = (cntHigh == syncLoVal);
  assign syncHi  = (cntHigh == syncHiVal);
endmodule

// File: rtl/fbk_pulse_divider.sv
module fbk_pulse_divider
  import fbdiv_pkg::*;
#(
  parameter int MOD_W  = 11,
  parameter int SYNC_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [MOD_W-1:0]     modVal,
  input  logic [PS_CODE_W-1:0] postCode,
  input  logic [SYNC_W-1:0]    syncLoVal,
  input  logic [SYNC_W-1:0]    syncHiVal,
  input  logic                 addCmd,
  input  logic                 swallowCmd,
  input  logic                 useInternal,
  input  logic                 extPol,
  input  logic                 extFbk,
  output logic                 fbkPulse,
  output logic                 syncLo,
  output logic                 syncHi
);
  fbdivCtl_t ctl;
  logic      divTc;

  fbdiv_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .addCmd(addCmd), .swallowCmd(swallowCmd),
    .useInternal(useInternal), .extPol(extPol), .extFbk(extFbk),
    .divTc(divTc), .ctl(ctl)
  );

  fbdiv_dp #(.MOD_W(MOD_W), .SYNC_W(SYNC_W)) dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modVal(modVal),
    .postCode(postCode), .syncLoVal(syncLoVal), .syncHiVal(syncHiVal),
    .ctl(ctl), .divTc(divTc), .fbkPulse(fbkPulse),
    .syncLo(syncLo), .syncHi(syncHi)
  );
endmodule

// File: rtl/fbdiv_chk.sv
module fbdiv_chk #(
  parameter int SYNC_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              useInternal,
  input logic              extPol,
  input logic              extFbk,
  input logic              intSel,
  input logic              fbkPulse,
  input logic              syncLo,
  input logic              syncHi,
  input logic [SYNC_W-1:0] syncLoVal,
  input logic [SYNC_W-1:0] syncHiVal
);
  AST_TICK_NEEDED: assert property (@(posedge clk) disable iff (!rstN)
    (fbkPulse && intSel && $past(intSel)) |-> $past(tickEn)); // R1

  AST_SYNC_APART: assert property (@(posedge clk) disable iff (!rstN)
    (syncLoVal != syncHiVal) |-> !(syncLo && syncHi)); // R6

  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!intSel && (extPol ? $fell(extFbk) : $rose(extFbk))) |=> fbkPulse); // R7

  AST_SWITCH_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intSel) |-> (fbkPulse && $past(useInternal))); // R8

  AST_DROP_TO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    !useInternal |=> !intSel); // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (fbkPulse && intSel && useInternal) |=> !fbkPulse); // R9
endmodule

bind fbk_pulse_divider fbdiv_chk #(.SYNC_W(SYNC_W)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .useInternal(useInternal),
  .extPol(extPol), .extFbk(extFbk), .intSel(ctl.selInt),
  .fbkPulse(fbkPulse), .syncLo(syncLo), .syncHi(syncHi),
  .syncLoVal(syncLoVal), .syncHiVal(syncHiVal)
);

// File: tb/fbk_pulse_divider_tb_top.sv
module fbk_pulse_divider_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b1;
  logic [10:0] modVal = 11'd63;
  logic [1:0]  postCode = 2'd3;
  logic [7:0]  syncLoVal = 8'd3;
  logic [7:0]  syncHiVal = 8'd6;
  logic        addCmd = 1'b0, swallowCmd = 1'b0;
  logic        useInternal = 1'b1, extPol = 1'b0, extFbk = 1'b0;
  logic        fbkPulse, syncLo, syncHi;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int tickMode = 1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tickEn <= (tickMode == 1) ? 1'b1 : ~tickEn;

  fbk_pulse_divider dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modVal(modVal),
    .postCode(postCode), .syncLoVal(syncLoVal), .syncHiVal(syncHiVal),
    .addCmd(addCmd), .swallowCmd(swallowCmd), .useInternal(useInternal),
    .extPol(extPol), .extFbk(extFbk), .fbkPulse(fbkPulse),
    .syncLo(syncLo), .syncHi(syncHi)
  );

  // Vector table: modulus-1, post code, tick mode, expected pulse gap in clocks
  localparam int VEC_N = 6;
  localparam int vecMod  [VEC_N] = '{63, 79, 63, 63, 63, 99};
  localparam int vecPost [VEC_N] = '{3, 3, 2, 1, 0, 3};
  localparam int vecTick [VEC_N] = '{1, 1, 1, 1, 1, 2};
  localparam int vecGap  [VEC_N] = '{64, 80, 128, 256, 512, 200};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic waitPulse(output int at);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!fbkPulse && guard < 5000);
    if (!fbkPulse) check(1'b0, "R1 pulse timeout", guard, 0);
    at = cyc;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int t0, t1, t2, mism, cnt;

    // R10 / R1: reset state and first pulse after reset
    doReset();
    t0 = cyc;
    @(negedge clk);
    check(fbkPulse == 1'b0, "R10 pulse low after reset", fbkPulse, 0);
    waitPulse(t1);
    check((t1 - t0) == 64, "R10 R1 first pulse after reset", t1 - t0, 64);

    // R1 / R2: table of modulus, post-scale and tick patterns
    for (int i = 0; i < VEC_N; i++) begin
      modVal = 11'(vecMod[i]);
      postCode = 2'(vecPost[i]);
      tickMode = vecTick[i];
      doReset();
      waitPulse(t0);
      waitPulse(t1);
      check((t1 - t0) == vecGap[i], (vecPost[i] == 3) ? "R1 period" : "R2 post-scale period",
            t1 - t0, vecGap[i]);
    end
    tickMode = 1;

    // R6: sync decode positions within an 80-tick period
    modVal = 11'd79; postCode = 2'd3;
    doReset();
    waitPulse(t0);
    mism = 0;
    for (int k = 0; k < 80; k++) begin
      if (k > 0) @(negedge clk);
      if (syncLo != (k >= 24 && k <= 31)) mism++;
      if (syncHi != (k >= 48 && k <= 55)) mism++;
    end
    check(mism == 0, "R6 sync decode mismatches", mism, 0);
    syncLoVal = 8'd0;
    @(negedge clk);
    waitPulse(t0);
    check(syncLo == 1'b1, "R6 syncLo at count zero", syncLo, 1);

    // R3: swallow lengthens one period only
    syncLoVal = 8'd3;
    modVal = 11'd63;
    doReset();
    waitPulse(t0);
    swallowCmd = 1'b1;
    waitPulse(t1);
    check((t1 - t0) == 65, "R3 swallow period", t1 - t0, 65);
    waitPulse(t2);
    check((t2 - t1) == 64, "R3 held swallow no repeat", t2 - t1, 64);
    swallowCmd = 1'b0;

    // R4: add shortens one period only
    waitPulse(t0);
    addCmd = 1'b1;
    waitPulse(t1);
    check((t1 - t0) == 63, "R4 add period", t1 - t0, 63);
    waitPulse(t2);
    check((t2 - t1) == 64, "R4 held add no repeat", t2 - t1, 64);
    addCmd = 1'b0;

    // R5: add and swallow raised on the same clock cancel
    waitPulse(t0);
    addCmd = 1'b1; swallowCmd = 1'b1;
    waitPulse(t1);
    check((t1 - t0) == 64, "R5 cancel period", t1 - t0, 64);
    waitPulse(t2);
    check((t2 - t1) == 64, "R5 nothing left pending", t2 - t1, 64);
    addCmd = 1'b0; swallowCmd = 1'b0;

    // R7: external mode, rising then falling polarity
    useInternal = 1'b0;
    repeat (3) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (fbkPulse) cnt++;
    end
    check(cnt == 0, "R7 internal pulses blocked", cnt, 0);
    extFbk = 1'b1;
    @(negedge clk);
    check(fbkPulse == 1'b1, "R7 rising edge pulse", fbkPulse, 1);
    @(negedge clk);
    check(fbkPulse == 1'b0, "R7 pulse one clock", fbkPulse, 0);
    extFbk = 1'b0;
    @(negedge clk);
    check(fbkPulse == 1'b0, "R7 falling ignored pol0", fbkPulse, 0);
    extPol = 1'b1;
    @(negedge clk);
    extFbk = 1'b1;
    @(negedge clk);
    check(fbkPulse == 1'b0, "R7 rising ignored pol1", fbkPulse, 0);
    extFbk = 1'b0;
    @(negedge clk);
    check(fbkPulse == 1'b1, "R7 falling edge pulse pol1", fbkPulse, 1);

    // R8: switchover waits for an edge and restarts the counter
    extPol = 1'b0;
    @(negedge clk);
    useInternal = 1'b1;
    cnt = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (fbkPulse) cnt++;
    end
    check(cnt == 0, "R8 no switch without edge", cnt, 0);
    extFbk = 1'b1;
    @(negedge clk);
    check(fbkPulse == 1'b1, "R8 switch edge pulse", fbkPulse, 1);
    mism = 0;
    for (int k = 1; k <= 70; k++) begin
      @(negedge clk);
      if (fbkPulse != (k == 64)) mism++;
      if (k == 10) extFbk = 1'b0;
      if (k == 30) extFbk = 1'b1;
    end
    check(mism == 0, "R8 internal pulse 64 after switch", mism, 0);

    finishRun();
  end
endmodule